// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the palette and attribute stage of a video pipeline. Its registers sit behind one shared 8-bit write port. An internal phase flag decides what each write means: in the index phase the byte selects a register, and in the data phase the byte is stored into that register. A status-read strobe from elsewhere in the chip puts the flag back into the index phase. Software uses that strobe to resynchronise before a sequence of accesses.

The index byte also carries a video-enable flag. While the flag is clear, the display shows the border (overscan) colour, and the sixteen palette entries can be written. While it is set, the palette entries are locked against writes.

Each cycle the block takes a 4-bit pixel and looks it up in the palette. It then combines the result with page bits from the colour-select register to form an 8-bit colour index for the DAC stage that follows. The page bits are applied in one of two paging modes.

Top module: `attr_ctl_port`

## Requirements
- R1: After reset, every register reads zero, the port is in the index phase and video is disabled, so `pix_out` is 0x00, `page_num` is 0 and `blink_en` is 0.
- R2: A cycle with `phase_rst` high forces the index phase. A write in the same cycle is discarded and changes no state.
- R3: A write in the index phase stores bits 4:0 of the byte as the register index and bit 5 as the video-enable flag; bits 7:6 are ignored. A write in the data phase stores into the indexed register. Every accepted write toggles the phase.
- R4: `rd_data` continuously returns the indexed register, and reading it never changes the phase. Palette entries 0x00..0x0F read as {2'b00, 6-bit entry}, 0x10 (mode) and 0x11 (overscan) read as 8 bits, and 0x14 (colour select) reads as {4'b0000, 4-bit value}.
- R5: While video-enable is clear, `pix_out` equals the overscan register. `pix_out` is registered, so it appears one clock after the inputs.
- R6: While video-enable is set, data writes to indices 0x00..0x0F are ignored. Writes to 0x10, 0x11 and 0x14 still take effect.
- R7: Data writes to indices 0x12, 0x13 and 0x15..0x1F change no register but still toggle the phase. These indices read as zero.
- R8: With video enabled and mode bit 7 clear, `pix_out` is {select[3:2], entry[5:0]}, where entry is the palette entry addressed by `pix_in` and select is the colour-select register.
- R9: With video enabled and mode bit 7 set, `pix_out` is {select[3:2], select[1:0], entry[3:0]}.
- R10: `page_num` is select[3:0] when mode bit 7 is set. It is {2'b00, select[3:2]} when mode bit 7 is clear.
- R11: `blink_en` follows bit 3 of the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Index byte or data byte |
| phase_rst | input | 1 | Status-read strobe; returns the port to the index phase |
| rd_data | output | 8 | Contents of the indexed register |
| pix_in | input | 4 | Pixel value to be mapped |
| pix_out | output | 8 | Mapped colour index, registered |
| page_num | output | 4 | Active page number |
| blink_en | output | 1 | Blink enable from the mode register |

## Verification
The bench targets the phase flag. It issues a strobe halfway through an index/data pair, and a strobe in the same cycle as a write. A design that toggled on the strobe, or kept that write, would store the next index byte into a register. The bench also writes the palette with video enabled and writes to the reserved indices; a design that got these wrong would corrupt an entry or read back non-zero. Finally, it maps pixels in both paging modes with entries whose upper bits differ, so swapped or wrongly masked select bits show up in `pix_out` and `page_num`.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int          IDX_W    = 5;
  localparam int          BYTE_W   = 8;
  localparam int          VEN_BIT  = 5;
  localparam logic [4:0]  IDX_MODE = 5'h10;
  localparam logic [4:0]  IDX_OVSC = 5'h11;
  localparam logic [4:0]  IDX_CSEL = 5'h14;
  localparam int          MODE_BLINK_BIT = 3;
  localparam int          MODE_PAGE_BIT  = 7;
endpackage

// File: rtl/attr_phase_ctl.sv
module attr_phase_ctl
  import attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              phase_rst,
  output logic              data_phase,
  output logic [IDX_W-1:0]  idx_q,
  output logic              video_en,
  output logic              data_wr
);
  logic             ph_q, ph_d;
  logic [IDX_W-1:0] idx_d;
  logic             ven_q, ven_d;
  logic             upd;

  always_comb begin
    ph_d    = ph_q;
    idx_d   = idx_q;
    ven_d   = ven_q;
    data_wr = 1'b0;
    if (phase_rst) begin
      ph_d = 1'b0;
    end else if (wr_en) begin
      ph_d = ~ph_q;
      if (!ph_q) begin
        idx_d = wr_data[IDX_W-1:0];
        ven_d = wr_data[VEN_BIT];
      end else begin
        data_wr = 1'b1;
      end
    end
  end

  assign upd = phase_rst | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      idx_q <= '0;
      ven_q <= 1'b0;
    end else if (upd) begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      ven_q <= ven_d;
    end
  end

  assign data_phase = ph_q;
  assign video_en   = ven_q;

  // R2
  strobe_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> !data_phase);

  // R2
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |=> ($stable(idx_q) && $stable(video_en)));

  // R3
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !phase_rst) |=> (data_phase != $past(data_phase)));
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAL_W   = 6,
  parameter int CS_W    = 4
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_wr,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     video_en,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [ENTRIES*PAL_W-1:0] pal_flat,
  output logic [BYTE_W-1:0]        mode_q,
  output logic [BYTE_W-1:0]        ovsc_q,
  output logic [CS_W-1:0]          csel_q,
  output logic [BYTE_W-1:0]        rd_data
);
  localparam int SEL_W = $clog2(ENTRIES);

  logic [PAL_W-1:0] pal_q [ENTRIES];
  logic             is_pal, mode_we, ovsc_we, csel_we, rsv_wr;

  assign is_pal  = (int'(idx) < ENTRIES);
  assign mode_we = data_wr && (idx == IDX_MODE);
  assign ovsc_we = data_wr && (idx == IDX_OVSC);
  assign csel_we = data_wr && (idx == IDX_CSEL);
  assign rsv_wr  = data_wr && !is_pal && (idx != IDX_MODE) &&
                   (idx != IDX_OVSC) && (idx != IDX_CSEL);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_pal
    logic ent_we;
    assign ent_we = data_wr && !video_en && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pal_q[i] <= '0;
      else if (ent_we) pal_q[i] <= wdata[PAL_W-1:0];
    end
    assign pal_flat[i*PAL_W +: PAL_W] = pal_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovsc_q <= '0;
    else if (ovsc_we) ovsc_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csel_q <= '0;
    else if (csel_we) csel_q <= wdata[CS_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (is_pal)                rd_data[PAL_W-1:0] = pal_q[idx[SEL_W-1:0]];
    else if (idx == IDX_MODE)  rd_data = mode_q;
    else if (idx == IDX_OVSC)  rd_data = ovsc_q;
    else if (idx == IDX_CSEL)  rd_data[CS_W-1:0] = csel_q;
  end

  // R6
  pal_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && video_en && is_pal) |=> $stable(pal_flat));

  // R7
  rsv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_wr |=> ($stable(pal_flat) && $stable(mode_q) &&
                $stable(ovsc_q) && $stable(csel_q)));
endmodule

// File: rtl/attr_pixmap.sv
module attr_pixmap
  import attr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAL_W   = 6,
  parameter int CS_W    = 4,
  parameter int PIX_W   = 4
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         pix_in,
  input  logic [ENTRIES*PAL_W-1:0] pal_flat,
  input  logic [BYTE_W-1:0]        mode_q,
  input  logic [BYTE_W-1:0]        ovsc_q,
  input  logic [CS_W-1:0]          csel_q,
  input  logic                     video_en,
  output logic [BYTE_W-1:0]        pix_out,
  output logic [CS_W-1:0]          page_num
);
  logic [PAL_W-1:0]  ent;
  logic [BYTE_W-1:0] pix_d;
  logic              paged;

  assign paged = mode_q[MODE_PAGE_BIT];
  assign ent   = pal_flat[int'(pix_in)*PAL_W +: PAL_W];

  always_comb begin
    if (!video_en)  pix_d = ovsc_q;
    else if (paged) pix_d = {csel_q[3:2], csel_q[1:0], ent[3:0]};
    else            pix_d = {csel_q[3:2], ent[5:0]};
  end

  always_comb begin
    if (paged) page_num = csel_q;
    else       page_num = {2'b00, csel_q[3:2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= pix_d;
  end

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |=> (pix_out == $past(ovsc_q)));

  // R9
  page_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_en && paged) |=> (pix_out[5:4] == $past(csel_q[1:0])));

  // R8
  top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |=> (pix_out[7:6] == $past(csel_q[3:2])));
endmodule

// File: rtl/attr_ctl_port.sv
module attr_ctl_port
  import attr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PAL_W   = 6,
  parameter int CS_W    = 4,
  parameter int PIX_W   = 4
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        phase_rst,
  output logic [7:0]  rd_data,
  input  logic [3:0]  pix_in,
  output logic [7:0]  pix_out,
  output logic [3:0]  page_num,
  output logic        blink_en
);
  logic [1:0]               rst_sync;
  logic                     core_rst_n;
  logic                     data_phase, video_en, data_wr;
  logic [IDX_W-1:0]         idx_q;
  logic [ENTRIES*PAL_W-1:0] pal_flat;
  logic [BYTE_W-1:0]        mode_q, ovsc_q;
  logic [CS_W-1:0]          csel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  attr_phase_ctl u_phase (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phase_rst(phase_rst), .data_phase(data_phase), .idx_q(idx_q),
    .video_en(video_en), .data_wr(data_wr)
  );

  attr_regfile #(.ENTRIES(ENTRIES), .PAL_W(PAL_W), .CS_W(CS_W)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .data_wr(data_wr), .idx(idx_q),
    .video_en(video_en), .wdata(wr_data), .pal_flat(pal_flat),
    .mode_q(mode_q), .ovsc_q(ovsc_q), .csel_q(csel_q), .rd_data(rd_data)
  );

  attr_pixmap #(.ENTRIES(ENTRIES), .PAL_W(PAL_W), .CS_W(CS_W), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(core_rst_n), .pix_in(pix_in), .pal_flat(pal_flat),
    .mode_q(mode_q), .ovsc_q(ovsc_q), .csel_q(csel_q), .video_en(video_en),
    .pix_out(pix_out), .page_num(page_num)
  );

  assign blink_en = mode_q[MODE_BLINK_BIT];

  // R11
  blink_follow_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (data_wr && idx_q == IDX_MODE) |=> (blink_en == $past(wr_data[3])));

  // R4
  rd_nochange_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!wr_en && !phase_rst) |=> $stable(rd_data));
endmodule

// File: tb/sim_attr_ctl_port.sv
module sim_attr_ctl_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       phase_rst = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] pix_in = 4'h0;
  logic [7:0] pix_out;
  logic [3:0] page_num;
  logic       blink_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [5:0] m_pal [16];
  logic [7:0] m_mode, m_ovs;
  logic [3:0] m_cs;
  logic [4:0] m_idx;
  logic       m_ven, m_ph;

  always #5 clk = ~clk;

  attr_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .phase_rst(phase_rst), .rd_data(rd_data), .pix_in(pix_in),
    .pix_out(pix_out), .page_num(page_num), .blink_en(blink_en)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (m_idx < 5'h10)       return {2'b00, m_pal[m_idx[3:0]]};
    else if (m_idx == 5'h10) return m_mode;
    else if (m_idx == 5'h11) return m_ovs;
    else if (m_idx == 5'h14) return {4'h0, m_cs};
    else                     return 8'h00;
  endfunction

  function automatic logic [7:0] exp_pix(input logic [3:0] p);
    logic [5:0] e;
    e = m_pal[p];
    if (!m_ven)        return m_ovs;
    else if (m_mode[7]) return {m_cs[3:2], m_cs[1:0], e[3:0]};
    else               return {m_cs[3:2], e};
  endfunction

  function automatic logic [3:0] exp_page();
    return m_mode[7] ? m_cs : {2'b00, m_cs[3:2]};
  endfunction

  task automatic model_write(input logic [7:0] b);
    if (!m_ph) begin
      m_idx = b[4:0];
      m_ven = b[5];
    end else begin
      if (m_idx < 5'h10) begin
        if (!m_ven) m_pal[m_idx[3:0]] = b[5:0];
      end else if (m_idx == 5'h10) m_mode = b;
      else if (m_idx == 5'h11) m_ovs = b;
      else if (m_idx == 5'h14) m_cs = b[3:0];
    end
    m_ph = ~m_ph;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(b);
  endtask

  task automatic strobe();
    phase_rst = 1'b1;
    @(negedge clk);
    phase_rst = 1'b0;
    m_ph = 1'b0;
  endtask

  task automatic strobe_wr(input logic [7:0] b);
    phase_rst = 1'b1; wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    phase_rst = 1'b0; wr_en = 1'b0;
    m_ph = 1'b0;
  endtask

  task automatic check_rd(input string tag);
    check(rd_data == exp_rd(), tag, rd_data, exp_rd());
  endtask

  task automatic check_pix(input logic [3:0] p, input string tag);
    pix_in = p;
    @(negedge clk);
    check(pix_out == exp_pix(p), tag, pix_out, exp_pix(p));
    check(page_num == exp_page(), {tag, " R10 page"}, {4'h0, page_num}, {4'h0, exp_page()});
    check(blink_en == m_mode[3], {tag, " R11 blink"}, {7'h0, blink_en}, {7'h0, m_mode[3]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_pal[i] = 6'h00;
    m_mode = 8'h00; m_ovs = 8'h00; m_cs = 4'h0;
    m_idx = 5'h00; m_ven = 1'b0; m_ph = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(rd_data == 8'h00, "R1 rd after reset", rd_data, 8'h00);
    check_pix(4'h5, "R1 pix after reset");

    // R3: index then data, bits 7:6 of index ignored
    wr(8'h03); wr(8'h35);
    check_rd("R3 pal3 write");
    wr(8'hC3); check_rd("R3 R4 upper index bits ignored");
    strobe();

    // R2: strobe mid-pair, then strobe coincident with a write
    wr(8'h05); strobe(); wr(8'h07); wr(8'h15);
    check_rd("R2 strobe restarts pair");
    wr(8'h08); strobe_wr(8'h3F); wr(8'h09); wr(8'h11);
    check_rd("R2 pal9 after dropped write");
    wr(8'h08); check_rd("R2 dropped write left pal8");
    strobe();

    // R11 / R5: mode and overscan, video off
    wr(8'h10); wr(8'h08); check_rd("R11 mode readback");
    wr(8'h11); wr(8'h5C); check_rd("R4 overscan readback");
    check_pix(4'h3, "R5 blank to overscan");
    wr(8'h14); wr(8'h0E); check_rd("R4 colour select readback");

    // R8: enable video, normal mode
    strobe(); wr(8'h23);
    check_pix(4'h3, "R8 normal mapping");
    // R6: palette locked
    wr(8'h11); check_rd("R6 locked pal3");
    check_pix(4'h3, "R6 pix unchanged");
    wr(8'h30); wr(8'h88); check_rd("R6 mode writable while locked");
    // R9: paging mode
    check_pix(4'h3, "R9 paging mapping");
    check_pix(4'h9, "R9 paging mapping pal9");

    // R7: reserved indices
    wr(8'h32); wr(8'h77); check_rd("R7 idx12 reads zero");
    wr(8'h33); wr(8'h5A); check_rd("R7 idx13 reads zero");
    wr(8'h1F); wr(8'h44); check_rd("R7 idx1F reads zero");
    wr(8'h10); check_rd("R7 mode intact after reserved writes");
    wr(8'h11); check_rd("R7 phase kept toggling");
    check_pix(4'h9, "R7 R5 blank after video off");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 7);
      if (op <= 2) begin
        logic [7:0] b;
        if (!m_ph) begin
          b = {2'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0),
               5'($urandom_range(0, 22))};
        end else begin
          b = 8'($urandom);
        end
        wr(b);
      end else if (op == 3) begin
        strobe();
      end else if (op == 4) begin
        strobe_wr(8'($urandom));
      end else if (op == 5) begin
        check_rd("R4 rnd");
      end else begin
        check_pix(4'($urandom_range(0, 15)), "R8 R9 rnd pix");
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule